// File: doc/BRIEF.md
# SPI Controller with Mode Fault Detection

This block is a byte-oriented SPI port that acts as either bus master or bus slave, selected by a control bit. Software programs the clock polarity, the clock phase and a master bit-rate code. In master mode, writing the data register while the port is idle starts an 8-bit exchange. In slave mode the byte written to the data register is returned to the remote master during the next selected frame. Every received byte lands in the data register, and a completion flag marks the end of each frame.

All four SPI pins are presented as separate input, output and output-enable signals, so the block sits behind any pad ring. While acting as master with its select pin configured as an input, an external low on that pin shows that another master has claimed the bus. The port then demotes itself to slave, stops driving the clock and data lines, and raises the completion flag. It stays a slave until software selects master mode again.

Top module: `spi_port`

## Requirements
- R1: With the master bit at 1 the port drives SCK and MOSI (sck_oe and mosi_oe high). With it at 0 it drives neither and is a slave. A slave drives MISO only while the select input is low.
- R2: While the master bit is 1, ss_is_input is 1 and ss_i is low, the port clears the master bit (master_o falls), aborts any frame and sets done_o.
- R3: After a mode fault the master bit stays 0, even once ss_i returns high, until a control write sets it to 1 again.
- R4: In master mode SCK rests at the clock-polarity value whenever no frame is in progress: low for polarity 0, high for polarity 1.
- R5: With phase 0 data is captured on the leading SCK edge and changed on the trailing edge. With phase 1 data is changed on the leading edge and captured on the trailing edge. This holds in both roles.
- R6: With cfg_dbl = 0, rate codes 0, 1, 2 and 3 give an SCK period of 4, 16, 64 and 128 system clocks. A master frame therefore ends 8 times that many cycles after the data write.
- R7: With cfg_dbl = 1, rate codes 0, 1, 2 and 3 give an SCK period of 2, 8, 32 and 64 system clocks, with the same 8-period frame length.
- R8: The rate code and the double-speed bit have no effect in slave mode. A slave frame is timed only by the external SCK.
- R9: Frames are 8 bits, most significant bit first. A data write starts a master frame only when the port is idle. A data write during a frame is ignored.
- R10: done_o is set at the end of every frame. It is cleared only by a status read (sts_rd) made while it is set, followed by a data access (dat_rd or dat_wr). A data access alone leaves it set.
- R11: In slave mode a high select input releases MISO and discards a partial frame, so the next frame is received whole.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_master | input | 1 | Control: 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Control: SCK idle level |
| cfg_cpha | input | 1 | Control: clock phase |
| cfg_rate | input | 2 | Control: master rate code |
| cfg_dbl | input | 1 | Control: double-speed bit |
| ss_is_input | input | 1 | Select pin direction: 1 = input |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Data to transmit |
| dat_rd | input | 1 | Data register read strobe |
| sts_rd | input | 1 | Status read strobe |
| dat_rdata | output | 8 | Last received byte |
| done_o | output | 1 | Completion flag |
| master_o | output | 1 | Current master bit |
| sck_i | input | 1 | SCK pad input |
| sck_o | output | 1 | SCK pad output |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI pad output |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO pad output |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Select pad input |
| ss_o | output | 1 | Select pad output (low during a master frame) |
| ss_oe | output | 1 | Select output enable |

## Verification
A master frame registers the data write on one edge and raises done_o exactly 8 SCK periods, 8 times the divisor in system clocks, after that edge. The bench counts falling clock edges from the write and requires done_o at exactly that count. Slave pins pass through a two-stage synchronizer and an edge register, so slave results appear three to four cycles after a pin change. The bench holds each SCK half period for eight cycles and samples MISO just before its own capture edge. A mode fault is checked four cycles after the select pin falls, which covers the two synchronizer stages and the control register.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   typedef struct packed {
      logic       master;
      logic       cpol;
      logic       cpha;
      logic [1:0] rate;
      logic       dbl;
   } spi_ctl_t;

   // largest half-period exponent of the rate table
   localparam int unsigned HALF_EXP_MAX = 6;

   // log2 of the SCK half period in system clocks
   function automatic logic [2:0] half_exp(input logic [1:0] rate, input logic dbl);
      logic [2:0] e;
      case (rate)
         2'd0:    e = 3'd1;
         2'd1:    e = 3'd3;
         2'd2:    e = 3'd5;
         default: e = 3'd6;
      endcase
      return dbl ? e - 3'd1 : e;
   endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("spi_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] st;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st <= RST_VAL;
         else        st <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st <= {STAGES{RST_VAL}};
         else        st <= {st[STAGES-2:0], d};
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
   import spi_port_pkg::*;
#(
   parameter int EXP_MAX = HALF_EXP_MAX
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] rate,
   input  logic       dbl,
   output logic       tick
);
   if (EXP_MAX < 1) begin : g_bad_exp
      $error("spi_clk_gen: EXP_MAX must be at least 1");
   end

   localparam int CW = EXP_MAX;

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      lim = CW'((32'd1 << half_exp(rate, dbl)) - 32'd1);
   end

   assign tick = run && (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (!run || restart || tick) cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end

   AST_IDLE_COUNTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0); // R6
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         cpha,
   input  logic         setup_ev,
   input  logic         sample_ev,
   input  logic         in_bit,
   output logic         out_bit,
   output logic [W-1:0] rx_q,
   output logic [W-1:0] rx_next
);
   if (W < 2) begin : g_bad_w
      $error("spi_shift_core: W must be at least 2");
   end

   // one spare bit: phase 1 shows the first bit only after the leading edge
   logic [W:0] out_q;

   assign out_bit = out_q[W];
   assign rx_next = {rx_q[W-2:0], in_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         rx_q  <= '0;
      end else if (load) begin
         out_q <= cpha ? {1'b0, load_data} : {load_data, 1'b0};
         rx_q  <= '0;
      end else begin
         if (setup_ev)  out_q <= {out_q[W-1:0], 1'b0};
         if (sample_ev) rx_q  <= rx_next;
      end
   end

   AST_LOAD_CLEARS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rx_q == '0); // R11
endmodule

// File: rtl/spi_port.sv
module spi_port
   import spi_port_pkg::*;
#(
   parameter int FRAME_BITS  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr,
   input  logic                  cfg_master,
   input  logic                  cfg_cpol,
   input  logic                  cfg_cpha,
   input  logic [1:0]            cfg_rate,
   input  logic                  cfg_dbl,
   input  logic                  ss_is_input,
   input  logic                  dat_wr,
   input  logic [FRAME_BITS-1:0] dat_wdata,
   input  logic                  dat_rd,
   input  logic                  sts_rd,
   output logic [FRAME_BITS-1:0] dat_rdata,
   output logic                  done_o,
   output logic                  master_o,
   input  logic                  sck_i,
   output logic                  sck_o,
   output logic                  sck_oe,
   input  logic                  mosi_i,
   output logic                  mosi_o,
   output logic                  mosi_oe,
   input  logic                  miso_i,
   output logic                  miso_o,
   output logic                  miso_oe,
   input  logic                  ss_i,
   output logic                  ss_o,
   output logic                  ss_oe
);
   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("spi_port: FRAME_BITS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_port: SYNC_STAGES must be at least 2");
   end

   localparam int EW = $clog2(2 * FRAME_BITS);
   localparam int SW = $clog2(FRAME_BITS);
   localparam logic [EW-1:0] LAST_EDGE = EW'(2 * FRAME_BITS - 1);
   localparam logic [SW-1:0] LAST_SAMP = SW'(FRAME_BITS - 1);

   spi_ctl_t             ctl_q;
   logic                 busy_q;
   logic                 sck_ph_q;
   logic [EW-1:0]        edge_cnt;
   logic [SW-1:0]        samp_cnt;
   logic                 done_q;
   logic                 armed_q;
   logic [FRAME_BITS-1:0] rdata_q;
   logic [FRAME_BITS-1:0] tx_hold_q;
   logic                 sck_d;

   // pin synchronizers
   logic sck_s, mosi_s, ss_s;

   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(mosi_i), .q(mosi_s));
   spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
      .clk(clk), .rst_n(rst_n), .d(ss_i), .q(ss_s));

   // control decode
   logic fault, start, tick, m_last;

   assign fault = ctl_q.master & ss_is_input & ~ss_s;
   assign start = dat_wr & ctl_q.master & ~busy_q & ~fault;

   spi_clk_gen u_clk_gen (
      .clk(clk), .rst_n(rst_n), .run(busy_q), .restart(start),
      .rate(ctl_q.rate), .dbl(ctl_q.dbl), .tick(tick));

   assign m_last = tick & (edge_cnt == LAST_EDGE);

   // edge classification for both roles
   logic s_active, s_rise, s_fall, s_lead, s_trail;
   logic lead_ev, trail_ev, setup_ev, sample_ev, in_bit, s_last;

   assign s_active = ~ctl_q.master & ~ss_s;
   assign s_rise   = sck_s & ~sck_d;
   assign s_fall   = ~sck_s & sck_d;
   assign s_lead   = s_active & (ctl_q.cpol ? s_fall : s_rise);
   assign s_trail  = s_active & (ctl_q.cpol ? s_rise : s_fall);

   assign lead_ev   = ctl_q.master ? (tick & ~sck_ph_q) : s_lead;
   assign trail_ev  = ctl_q.master ? (tick &  sck_ph_q) : s_trail;
   assign setup_ev  = ctl_q.cpha ? lead_ev  : trail_ev;
   assign sample_ev = ctl_q.cpha ? trail_ev : lead_ev;
   assign in_bit    = ctl_q.master ? miso_i : mosi_s;
   assign s_last    = ~ctl_q.master & sample_ev & (samp_cnt == LAST_SAMP);

   // shift datapath
   logic                  core_load, out_bit;
   logic [FRAME_BITS-1:0] load_data, rx_q, rx_next;

   assign core_load = start | (~ctl_q.master & ss_s);
   assign load_data = start ? dat_wdata : tx_hold_q;

   spi_shift_core #(.W(FRAME_BITS)) u_core (
      .clk(clk), .rst_n(rst_n), .load(core_load), .load_data(load_data),
      .cpha(ctl_q.cpha), .setup_ev(setup_ev), .sample_ev(sample_ev),
      .in_bit(in_bit), .out_bit(out_bit), .rx_q(rx_q), .rx_next(rx_next));

   // completion flag handling
   logic done_set, done_clr;

   assign done_set = fault | m_last | s_last;
   assign done_clr = armed_q & (dat_rd | dat_wr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (cfg_wr) begin
            ctl_q.master <= cfg_master;
            ctl_q.cpol   <= cfg_cpol;
            ctl_q.cpha   <= cfg_cpha;
            ctl_q.rate   <= cfg_rate;
            ctl_q.dbl    <= cfg_dbl;
         end
         if (fault) ctl_q.master <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         sck_ph_q <= 1'b0;
         edge_cnt <= '0;
      end else if (fault || !ctl_q.master) begin
         busy_q   <= 1'b0;
         sck_ph_q <= 1'b0;
         edge_cnt <= '0;
      end else if (start) begin
         busy_q   <= 1'b1;
         sck_ph_q <= 1'b0;
         edge_cnt <= '0;
      end else if (tick) begin
         sck_ph_q <= ~sck_ph_q;
         edge_cnt <= m_last ? '0 : edge_cnt + 1'b1;
         if (m_last) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_cnt <= '0;
         sck_d    <= 1'b0;
      end else begin
         sck_d <= sck_s;
         if (ctl_q.master || ss_s) samp_cnt <= '0;
         else if (sample_ev)       samp_cnt <= s_last ? '0 : samp_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (done_set) begin
            done_q  <= 1'b1;
            armed_q <= 1'b0;
         end else if (done_clr) begin
            done_q  <= 1'b0;
            armed_q <= 1'b0;
         end else if (sts_rd && done_q) begin
            armed_q <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q   <= '0;
         tx_hold_q <= '0;
      end else begin
         if (m_last)      rdata_q <= sample_ev ? rx_next : rx_q;
         else if (s_last) rdata_q <= rx_next;
         if (dat_wr && (!ctl_q.master || start)) tx_hold_q <= dat_wdata;
      end
   end

   // pins
   assign sck_o     = ctl_q.cpol ^ sck_ph_q;
   assign sck_oe    = ctl_q.master;
   assign mosi_o    = out_bit;
   assign mosi_oe   = ctl_q.master;
   assign miso_o    = out_bit;
   assign miso_oe   = ~ctl_q.master & ~ss_s;
   assign ss_o      = ~busy_q;
   assign ss_oe     = ctl_q.master & ~ss_is_input;
   assign dat_rdata = rdata_q;
   assign done_o    = done_q;
   assign master_o  = ctl_q.master;

   // checks
   AST_FAULT_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q.master && ss_is_input && !ss_s |=> !ctl_q.master && done_q); // R2
   AST_MASTER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.master && !cfg_wr |=> !ctl_q.master); // R3
   AST_SLAVE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q.master |=> !busy_q); // R1
   AST_SCK_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> sck_o == ctl_q.cpol); // R4
   AST_SLAVE_COUNT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      ss_s |=> samp_cnt == '0); // R11
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !armed_q |=> done_q); // R10
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0, cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [1:0] cfg_rate = 2'd0;
   logic       cfg_dbl = 1'b0;
   logic       ss_is_input = 1'b1;
   logic       dat_wr = 1'b0, dat_rd = 1'b0, sts_rd = 1'b0;
   logic [7:0] dat_wdata = 8'h00;
   logic [7:0] dat_rdata;
   logic       done_o, master_o;
   logic       sck_i = 1'b0, sck_o, sck_oe;
   logic       mosi_i = 1'b0, mosi_o, mosi_oe;
   logic       miso_i, miso_o, miso_oe;
   logic       ss_i = 1'b1, ss_o, ss_oe;
   logic       loop_en = 1'b1;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   localparam int H = 8;

   assign miso_i = loop_en ? mosi_o : 1'b0;

   always #5 clk = ~clk;

   spi_port u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_master(cfg_master),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .cfg_dbl(cfg_dbl),
      .ss_is_input(ss_is_input), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
      .dat_rd(dat_rd), .sts_rd(sts_rd), .dat_rdata(dat_rdata), .done_o(done_o),
      .master_o(master_o), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i),
      .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe));

   function automatic int exp_div(input logic [1:0] rate, input logic dbl);
      int base;
      case (rate)
         2'd0: base = 4;
         2'd1: base = 16;
         2'd2: base = 64;
         default: base = 128;
      endcase
      return dbl ? base / 2 : base;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input logic m, input logic pol, input logic pha,
                          input logic [1:0] rate, input logic dbl);
      cfg_master = m; cfg_cpol = pol; cfg_cpha = pha; cfg_rate = rate; cfg_dbl = dbl;
      cfg_wr = 1'b1;
      cyc(1);
      cfg_wr = 1'b0;
   endtask

   task automatic clear_done();
      sts_rd = 1'b1; cyc(1); sts_rd = 1'b0;
      dat_rd = 1'b1; cyc(1); dat_rd = 1'b0;
   endtask

   // write one byte, optionally write again mid-frame, count cycles to done
   task automatic master_frame(input logic [7:0] d, input int wr2_at,
                               input logic [7:0] d2, output int n);
      dat_wdata = d; dat_wr = 1'b1;
      @(negedge clk);
      dat_wr = 1'b0;
      n = 0;
      while (!done_o && n < 3000) begin
         @(negedge clk);
         n++;
         dat_wr = 1'b0;
         if (n == wr2_at) begin
            dat_wdata = d2; dat_wr = 1'b1;
         end
      end
      dat_wr = 1'b0;
   endtask

   // bench acts as remote master
   task automatic slave_frame(input logic pha, input logic pol, input logic [7:0] mo,
                              input int nbits, output logic [7:0] mi);
      mi = 8'h00;
      ss_i = 1'b0;
      cyc(H);
      for (int i = 0; i < nbits; i++) begin
         if (!pha) begin
            mosi_i = mo[7-i];
            cyc(H);
            mi = {mi[6:0], miso_o};
            sck_i = ~pol;
            cyc(H);
            sck_i = pol;
         end else begin
            sck_i = ~pol;
            cyc(1);
            mosi_i = mo[7-i];
            cyc(H - 1);
            mi = {mi[6:0], miso_o};
            sck_i = pol;
            cyc(H);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         ended = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int n;
      logic [7:0] d, mi, sd;
      void'($urandom(32'd2024));
      cyc(4);
      rst_n = 1'b1;
      cyc(2);
      // reset state
      chk(done_o == 1'b0, "R10 reset done", done_o, 0);
      chk(master_o == 1'b0 && sck_oe == 1'b0 && mosi_oe == 1'b0, "R1 reset slave", master_o, 0);
      chk(miso_oe == 1'b0, "R11 reset miso released", miso_oe, 0);

      // master: every mode and every divisor, loopback
      loop_en = 1'b1;
      for (int m = 0; m < 4; m++) begin
         for (int r = 0; r < 8; r++) begin
            logic pol, pha, dbl;
            logic [1:0] rate;
            pol = m[1]; pha = m[0]; rate = r[1:0]; dbl = r[2];
            set_cfg(1'b1, pol, pha, rate, dbl);
            cyc(2);
            chk(sck_o == pol, "R4 idle level before", sck_o, pol);
            chk(sck_oe && mosi_oe && !miso_oe, "R1 master drives", sck_oe, 1);
            d = 8'($urandom);
            master_frame(d, 0, 8'h00, n);
            chk(n == 8 * exp_div(rate, dbl), dbl ? "R7 frame cycles" : "R6 frame cycles",
                n, 8 * exp_div(rate, dbl));
            chk(dat_rdata == d, "R5 loopback data", dat_rdata, d);
            chk(sck_o == pol, "R4 idle level after", sck_o, pol);
            clear_done();
            chk(done_o == 1'b0, "R10 cleared", done_o, 0);
         end
      end

      // write during a frame is ignored
      set_cfg(1'b1, 1'b0, 1'b0, 2'd1, 1'b0);
      cyc(2);
      master_frame(8'hA5, 20, 8'h3C, n);
      chk(n == 128, "R9 frame not restarted", n, 128);
      chk(dat_rdata == 8'hA5, "R9 mid-frame write ignored", dat_rdata, 8'hA5);
      // data access alone does not clear
      dat_rd = 1'b1; cyc(1); dat_rd = 1'b0; cyc(1);
      chk(done_o == 1'b1, "R10 read without status", done_o, 1);
      clear_done();
      chk(done_o == 1'b0, "R10 status then data clears", done_o, 0);

      // mode fault
      ss_is_input = 1'b1; ss_i = 1'b1;
      set_cfg(1'b1, 1'b1, 1'b0, 2'd2, 1'b0);
      cyc(2);
      dat_wdata = 8'h5A; dat_wr = 1'b1; cyc(1); dat_wr = 1'b0;
      cyc(10);
      ss_i = 1'b0;
      cyc(4);
      chk(master_o == 1'b0, "R2 master cleared", master_o, 0);
      chk(done_o == 1'b1, "R2 done raised", done_o, 1);
      chk(sck_oe == 1'b0 && mosi_oe == 1'b0, "R2 pins released", sck_oe, 0);
      ss_i = 1'b1;
      cyc(10);
      chk(master_o == 1'b0, "R3 stays slave", master_o, 0);
      clear_done();
      set_cfg(1'b1, 1'b0, 1'b1, 2'd0, 1'b1);
      cyc(1);
      chk(master_o == 1'b1, "R3 master restored", master_o, 1);
      master_frame(8'hC3, 0, 8'h00, n);
      chk(n == 16 && dat_rdata == 8'hC3, "R3 frame after restore", dat_rdata, 8'hC3);
      clear_done();

      // slave: every mode, two rate settings each
      loop_en = 1'b0;
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 2; k++) begin
            logic pol, pha;
            logic [2:0] rr;
            pol = m[1]; pha = m[0];
            rr = 3'($urandom);
            sck_i = pol; ss_i = 1'b1;
            set_cfg(1'b0, pol, pha, rr[1:0], rr[2]);
            sd = 8'($urandom);
            dat_wdata = sd; dat_wr = 1'b1; cyc(1); dat_wr = 1'b0;
            cyc(4);
            chk(miso_oe == 1'b0, "R11 miso released while deselected", miso_oe, 0);
            d = 8'($urandom);
            slave_frame(pha, pol, d, 8, mi);
            cyc(6);
            chk(done_o == 1'b1, "R10 slave done", done_o, 1);
            chk(dat_rdata == d, k ? "R8 slave rx any rate" : "R5 slave rx", dat_rdata, d);
            chk(mi == sd, "R9 slave tx msb first", mi, sd);
            ss_i = 1'b1;
            cyc(4);
            chk(miso_oe == 1'b0, "R11 miso released after frame", miso_oe, 0);
            clear_done();
         end
      end

      // partial frame discarded by deselect
      sck_i = 1'b0; ss_i = 1'b1;
      set_cfg(1'b0, 1'b0, 1'b0, 2'd3, 1'b1);
      dat_wdata = 8'h96; dat_wr = 1'b1; cyc(1); dat_wr = 1'b0;
      cyc(4);
      slave_frame(1'b0, 1'b0, 8'hFF, 3, mi);
      ss_i = 1'b1;
      cyc(6);
      chk(done_o == 1'b0, "R11 partial frame no done", done_o, 0);
      slave_frame(1'b0, 1'b0, 8'h21, 8, mi);
      cyc(6);
      chk(done_o == 1'b1 && dat_rdata == 8'h21, "R11 next frame whole", dat_rdata, 8'h21);
      chk(mi == 8'h96, "R11 tx restarted", mi, 8'h96);
      ss_i = 1'b1;
      cyc(4);

      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule